// File: doc/BRIEF.md
# Instruction Fetch Bundle Queue

This block is a small ring of bundle slots between a fetch-address generator, an instruction cache and a decode stage. An accepted fetch request takes the next free slot. The slot records the bundle's start address, a per-lane enable mask, a branch state, a prediction id and an in-bundle lane pointer. The slot index goes back to the requester as a tag. The requester sends that tag with its cache lookup.

Cache responses carry the tag, one instruction word per lane and a bus-error flag. They may come back in any order, and each one fills the slot its tag names. Decode always sees the oldest allocated bundle. It sees that bundle only once the cache data for it has arrived. Each lane has its own valid/ready pair, so decode may take some lanes now and the rest later. The slot is released once every enabled lane has been taken.

A flush handshake drops every queued bundle and returns the ring to its reset state.

Top module: `fetch_bundle_queue`

## Requirements
- R1: A synchronous active-low reset leaves every slot empty and both ring pointers at zero. After reset, `req_ready` is 1, `req_tag` is 0, every `dec_valid` bit is 0, and `rsp_ready` and `flush_ready` are 1.
- R2: A fetch request is accepted when `req_valid` and `req_ready` are both high. At that time `req_tag` gives the index of the slot being allocated. Successive accepted requests get indices 0, 1, 2, … and wrap modulo SLOTS.
- R3: `req_ready` is low while all SLOTS slots hold bundles that have not been released.
- R4: `rsp_ready` is always 1. A response stores its lane words and error flag in the slot named by `rsp_tag` only if that slot is waiting for cache data. A response naming an empty slot or an already-filled slot changes nothing.
- R5: Lane i of `dec_valid` is high only while the oldest slot holds cache data, its enable bit i is 1, and that lane has not yet been taken.
- R6: Bundles reach decode strictly in the order their requests were accepted, whatever order their responses arrive in.
- R7: The `dec_insn` bits [i*IW +: IW] carry the response word from the `rsp_insn` bits [i*IW +: IW] of that bundle.
- R8: A lane is taken when its valid and ready are both high. Untaken enabled lanes stay valid with unchanged data. The oldest slot is released in the cycle its last enabled lane is taken, and the next bundle may be presented in the following cycle.
- R9: `dec_addr`, `dec_lane_en`-derived validity, `dec_lane_ptr`, `dec_br_state` and `dec_pred_id` equal the values captured with the request.
- R10: `dec_exc` is 2'b01 (fetch bus error) when the bundle's response had `rsp_bus_err` set, and 2'b00 (none) otherwise.
- R11: `flush_ready` is always 1. An accepted flush empties every slot and clears both pointers. A request, response or lane take in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | A free slot exists |
| req_tag | output | TAGW | Index of the slot a request would take |
| req_addr | input | AW | Bundle start address |
| req_lane_en | input | LANES | Enabled lanes, a prefix from lane 0 |
| req_lane_ptr | input | LPW | In-bundle lane pointer |
| req_br_state | input | BSW | Branch state |
| req_pred_id | input | PIDW | Prediction id |
| rsp_valid | input | 1 | Cache response valid |
| rsp_ready | output | 1 | Always 1 |
| rsp_tag | input | TAGW | Slot index the response belongs to |
| rsp_insn | input | LANES*IW | Instruction words, lane i at [i*IW +: IW] |
| rsp_bus_err | input | 1 | Bus error on this fetch |
| dec_valid | output | LANES | Per-lane valid toward decode |
| dec_ready | input | LANES | Per-lane ready from decode |
| dec_insn | output | LANES*IW | Per-lane instruction words |
| dec_addr | output | AW | Start address of the presented bundle |
| dec_lane_ptr | output | LPW | In-bundle lane pointer of the bundle |
| dec_br_state | output | BSW | Branch state of the bundle |
| dec_pred_id | output | PIDW | Prediction id of the bundle |
| dec_exc | output | 2 | Exception code: 00 none, 01 fetch bus error |
| flush_valid | input | 1 | Flush request |
| flush_ready | output | 1 | Always 1 |

## Verification
Suppose a slot's state is wrong. If it wrongly reads as filled, decode is offered a bundle before its response, in the very next cycle. If it is stuck waiting or empty, `dec_valid` never rises for that bundle, and every later bundle is blocked behind it. A lost or duplicated head advance shows up at the first release, as a skipped or repeated bundle address. A lane-taken mask that fails to clear makes the next bundle arrive with lanes missing. The bench stops each such error at the first bundle it touches, by comparing address, lane data and exception code with a model built from the requests it sent.

// File: rtl/fbq_pkg.sv
package fbq_pkg;

   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_READY = 2'd2
   } slot_st_e;

   typedef enum logic [1:0] {
      EXC_NONE = 2'd0,
      EXC_BUS  = 2'd1
   } exc_e;

endpackage

// File: rtl/fbq_ring_ptr.sv
module fbq_ring_ptr #(
   parameter int DEPTH = 4,
   localparam int W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] ptr
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [W-1:0] nxt;

   generate
      if (POW2) begin : g_natural_wrap
         assign nxt = ptr + W'(1);
      end else begin : g_explicit_wrap
         assign nxt = (ptr == W'(DEPTH - 1)) ? '0 : ptr + W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) ptr <= '0;
      else if (inc)      ptr <= nxt;
   end

endmodule

// File: rtl/fbq_slot_store.sv
module fbq_slot_store
   import fbq_pkg::*;
#(
   parameter int SLOTS = 4,
   parameter int MW    = 40,
   parameter int DW    = 64,
   localparam int TAGW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       alloc_en,
   input  logic [TAGW-1:0]            alloc_idx,
   input  logic [MW-1:0]              alloc_meta,
   input  logic                       fill_en,
   input  logic [TAGW-1:0]            fill_idx,
   input  logic [DW-1:0]              fill_data,
   input  logic                       fill_err,
   input  logic                       retire_en,
   input  logic [TAGW-1:0]            retire_idx,
   input  logic [TAGW-1:0]            rd_idx,
   output slot_st_e [SLOTS-1:0]       state_o,
   output logic [MW-1:0]              rd_meta,
   output logic [DW-1:0]              rd_data,
   output logic                       rd_err
);

   slot_st_e    st_q   [SLOTS];
   logic [MW-1:0] meta_q [SLOTS];
   logic [DW-1:0] data_q [SLOTS];
   logic          err_q  [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || flush)                                st_q[s] <= SLOT_EMPTY;
         else if (alloc_en && alloc_idx == TAGW'(s))          st_q[s] <= SLOT_WAIT;
         else if (fill_en && fill_idx == TAGW'(s))            st_q[s] <= SLOT_READY;
         else if (retire_en && retire_idx == TAGW'(s))        st_q[s] <= SLOT_EMPTY;
      end

      always_ff @(posedge clk) begin
         if (alloc_en && alloc_idx == TAGW'(s)) meta_q[s] <= alloc_meta;
         if (fill_en && fill_idx == TAGW'(s)) begin
            data_q[s] <= fill_data;
            err_q[s]  <= fill_err;
         end
      end

      assign state_o[s] = st_q[s];
   end

   assign rd_meta = meta_q[rd_idx];
   assign rd_data = data_q[rd_idx];
   assign rd_err  = err_q[rd_idx];

   // R2
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> st_q[alloc_idx] == SLOT_EMPTY);

   // R4
   fill_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> st_q[fill_idx] == SLOT_WAIT);

endmodule

// File: rtl/fbq_lane_track.sv
module fbq_lane_track #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             head_ready,
   input  logic [LANES-1:0] lane_en,
   input  logic [LANES-1:0] lane_ready,
   output logic [LANES-1:0] lane_valid,
   output logic             retire
);

   logic [LANES-1:0] taken_q;
   logic [LANES-1:0] fire;

   assign lane_valid = head_ready ? (lane_en & ~taken_q) : '0;
   assign fire       = lane_valid & lane_ready;
   assign retire     = head_ready && (((taken_q | fire) & lane_en) == lane_en);

   always_ff @(posedge clk) begin
      if (!rst_n || flush || retire) taken_q <= '0;
      else                           taken_q <= taken_q | fire;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      // R8
      taken_lane_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fire[i] && !retire && !flush) |=> !lane_valid[i]);
   end

endmodule

// File: rtl/fetch_bundle_queue.sv
module fetch_bundle_queue
   import fbq_pkg::*;
#(
   parameter int LANES = 2,
   parameter int SLOTS = 4,
   parameter int AW    = 32,
   parameter int IW    = 32,
   parameter int BSW   = 2,
   parameter int PIDW  = 3,
   localparam int TAGW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int LPW  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   output logic [TAGW-1:0]     req_tag,
   input  logic [AW-1:0]       req_addr,
   input  logic [LANES-1:0]    req_lane_en,
   input  logic [LPW-1:0]      req_lane_ptr,
   input  logic [BSW-1:0]      req_br_state,
   input  logic [PIDW-1:0]     req_pred_id,
   input  logic                rsp_valid,
   output logic                rsp_ready,
   input  logic [TAGW-1:0]     rsp_tag,
   input  logic [LANES*IW-1:0] rsp_insn,
   input  logic                rsp_bus_err,
   output logic [LANES-1:0]    dec_valid,
   input  logic [LANES-1:0]    dec_ready,
   output logic [LANES*IW-1:0] dec_insn,
   output logic [AW-1:0]       dec_addr,
   output logic [LPW-1:0]      dec_lane_ptr,
   output logic [BSW-1:0]      dec_br_state,
   output logic [PIDW-1:0]     dec_pred_id,
   output logic [1:0]          dec_exc,
   input  logic                flush_valid,
   output logic                flush_ready
);

   localparam int MW = AW + LANES + LPW + BSW + PIDW;
   localparam int DW = LANES * IW;
   localparam logic [TAGW:0] SLOTS_W = (TAGW + 1)'(SLOTS);

   generate
      if (SLOTS < 2)  begin : g_bad_slots  $error("SLOTS must be at least 2"); end
      if (LANES < 1)  begin : g_bad_lanes  $error("LANES must be at least 1"); end
      if (IW < 1 || AW < 1) begin : g_bad_width $error("AW and IW must be positive"); end
   endgenerate

   slot_st_e [SLOTS-1:0] slot_st;
   logic [TAGW-1:0] head, tail;
   logic [MW-1:0]   head_meta;
   logic [DW-1:0]   head_data;
   logic            head_err;
   logic            flush_fire, alloc, fill, retire, head_ready;
   logic [LANES-1:0] head_en;

   assign flush_ready = 1'b1;
   assign rsp_ready   = 1'b1;
   assign flush_fire  = flush_valid;

   assign req_ready  = slot_st[tail] == SLOT_EMPTY;
   assign req_tag    = tail;
   assign alloc      = req_valid && req_ready && !flush_fire;
   assign fill       = rsp_valid && !flush_fire && ({1'b0, rsp_tag} < SLOTS_W)
                       && slot_st[rsp_tag] == SLOT_WAIT;
   assign head_ready = slot_st[head] == SLOT_READY;

   fbq_ring_ptr #(.DEPTH(SLOTS)) u_tail (
      .clk(clk), .rst_n(rst_n), .clr(flush_fire), .inc(alloc), .ptr(tail));

   fbq_ring_ptr #(.DEPTH(SLOTS)) u_head (
      .clk(clk), .rst_n(rst_n), .clr(flush_fire), .inc(retire && !flush_fire), .ptr(head));

   fbq_slot_store #(.SLOTS(SLOTS), .MW(MW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush_fire),
      .alloc_en(alloc), .alloc_idx(tail),
      .alloc_meta({req_addr, req_lane_en, req_lane_ptr, req_br_state, req_pred_id}),
      .fill_en(fill), .fill_idx(rsp_tag), .fill_data(rsp_insn), .fill_err(rsp_bus_err),
      .retire_en(retire && !flush_fire), .retire_idx(head),
      .rd_idx(head), .state_o(slot_st),
      .rd_meta(head_meta), .rd_data(head_data), .rd_err(head_err));

   assign {dec_addr, head_en, dec_lane_ptr, dec_br_state, dec_pred_id} = head_meta;
   assign dec_insn = head_data;
   assign dec_exc  = head_err ? 2'(EXC_BUS) : 2'(EXC_NONE);

   fbq_lane_track #(.LANES(LANES)) u_lanes (
      .clk(clk), .rst_n(rst_n), .flush(flush_fire),
      .head_ready(head_ready), .lane_en(head_en), .lane_ready(dec_ready),
      .lane_valid(dec_valid), .retire(retire));

   // R11
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (dec_valid == '0 && req_ready && req_tag == '0));

   // R5
   valid_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid != '0) |-> slot_st[head] == SLOT_READY);

endmodule

// File: tb/tb_fetch_bundle_queue.sv
module tb_fetch_bundle_queue;

   localparam int LANES = 2, SLOTS = 4, AW = 32, IW = 32, BSW = 2, PIDW = 3;
   localparam int TAGW = 2, LPW = 1;

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  en;
      logic        lptr;
      logic [1:0]  br;
      logic [2:0]  pid;
      logic        err;
   } vec_t;

   // request table: allocated in order, filled later in a scrambled order
   localparam vec_t VEC [4] = '{
      '{addr:32'h0000_1000, en:2'b11, lptr:1'b0, br:2'd1, pid:3'd5, err:1'b0},
      '{addr:32'h0000_1008, en:2'b01, lptr:1'b1, br:2'd2, pid:3'd6, err:1'b0},
      '{addr:32'h0000_1010, en:2'b11, lptr:1'b0, br:2'd3, pid:3'd7, err:1'b1},
      '{addr:32'h0000_1018, en:2'b11, lptr:1'b1, br:2'd0, pid:3'd1, err:1'b0}
   };

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_ready;
   logic [TAGW-1:0] req_tag;
   logic [AW-1:0] req_addr = '0;
   logic [LANES-1:0] req_lane_en = '0;
   logic [LPW-1:0] req_lane_ptr = '0;
   logic [BSW-1:0] req_br_state = '0;
   logic [PIDW-1:0] req_pred_id = '0;
   logic rsp_valid = 0, rsp_ready;
   logic [TAGW-1:0] rsp_tag = '0;
   logic [LANES*IW-1:0] rsp_insn = '0;
   logic rsp_bus_err = 0;
   logic [LANES-1:0] dec_valid, dec_ready = '0;
   logic [LANES*IW-1:0] dec_insn;
   logic [AW-1:0] dec_addr;
   logic [LPW-1:0] dec_lane_ptr;
   logic [BSW-1:0] dec_br_state;
   logic [PIDW-1:0] dec_pred_id;
   logic [1:0] dec_exc;
   logic flush_valid = 0, flush_ready;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   fetch_bundle_queue #(.LANES(LANES), .SLOTS(SLOTS), .AW(AW), .IW(IW), .BSW(BSW), .PIDW(PIDW)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_addr(req_addr),
      .req_lane_en(req_lane_en), .req_lane_ptr(req_lane_ptr), .req_br_state(req_br_state),
      .req_pred_id(req_pred_id),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_insn(rsp_insn),
      .rsp_bus_err(rsp_bus_err),
      .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_insn(dec_insn), .dec_addr(dec_addr),
      .dec_lane_ptr(dec_lane_ptr), .dec_br_state(dec_br_state), .dec_pred_id(dec_pred_id),
      .dec_exc(dec_exc), .flush_valid(flush_valid), .flush_ready(flush_ready));

   function automatic logic [31:0] word_of(input logic [31:0] a);
      return a ^ 32'hC0DE_F00D;
   endfunction

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic do_req(input vec_t v, input int exp_tag);
      @(negedge clk);
      req_valid = 1; req_addr = v.addr; req_lane_en = v.en; req_lane_ptr = v.lptr;
      req_br_state = v.br; req_pred_id = v.pid;
      #2;
      chk("R3 ready with space", 64'(req_ready), 64'(1));
      chk("R2 tag", 64'(req_tag), 64'(exp_tag));
      @(posedge clk); #1 req_valid = 0;
   endtask

   task automatic do_rsp(input int tag, input logic [31:0] a, input logic err);
      @(negedge clk);
      rsp_valid = 1; rsp_tag = TAGW'(tag); rsp_bus_err = err;
      rsp_insn = {word_of(a + 32'd4), word_of(a)};
      #2 chk("R4 rsp_ready", 64'(rsp_ready), 64'(1));
      @(posedge clk); #1 rsp_valid = 0;
   endtask

   task automatic dec_step(input string what, input logic [1:0] ack, input logic [1:0] exp_v,
                           input vec_t v);
      @(negedge clk);
      dec_ready = ack;
      #2;
      chk({what, " dec_valid"}, 64'(dec_valid), 64'(exp_v));
      if (exp_v != 2'b00) begin
         for (int i = 0; i < LANES; i++)
            if (exp_v[i]) chk({what, " R7 lane word"}, 64'(dec_insn[i*IW +: IW]),
                              64'(word_of(v.addr + 32'(4 * i))));
         chk({what, " R9 addr"}, 64'(dec_addr), 64'(v.addr));
         chk({what, " R9 meta"}, 64'({dec_lane_ptr, dec_br_state, dec_pred_id}),
             64'({v.lptr, v.br, v.pid}));
         chk({what, " R10 exc"}, 64'(dec_exc), v.err ? 64'(2'b01) : 64'(2'b00));
      end
      @(posedge clk); #1 dec_ready = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      vec_t nv, fv, gv;
      nv = '{addr:32'h0000_2000, en:2'b11, lptr:1'b0, br:2'd1, pid:3'd2, err:1'b0};
      fv = '{addr:32'h0000_3000, en:2'b11, lptr:1'b1, br:2'd2, pid:3'd3, err:1'b0};
      gv = '{addr:32'h0000_4000, en:2'b11, lptr:1'b0, br:2'd3, pid:3'd4, err:1'b1};

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #2;
      // R1
      chk("R1 req_ready", 64'(req_ready), 64'(1));
      chk("R1 req_tag", 64'(req_tag), 64'(0));
      chk("R1 dec_valid", 64'(dec_valid), 64'(0));
      chk("R1 handshakes", 64'({rsp_ready, flush_ready}), 64'(2'b11));

      // R2: table walk, tags in order
      for (int k = 0; k < 4; k++) do_req(VEC[k], k);

      // R3: full
      @(negedge clk);
      req_valid = 1; req_addr = 32'hDEAD_0000;
      #2 chk("R3 full", 64'(req_ready), 64'(0));
      @(posedge clk); #1 req_valid = 0;

      // R5/R6: nothing before head data
      dec_step("R5 empty head", 2'b11, 2'b00, VEC[0]);
      do_rsp(2, VEC[2].addr, VEC[2].err);
      dec_step("R6 younger filled", 2'b11, 2'b00, VEC[0]);
      do_rsp(1, VEC[1].addr, VEC[1].err);
      dec_step("R6 head still waiting", 2'b11, 2'b00, VEC[0]);
      do_rsp(0, VEC[0].addr, VEC[0].err);
      // R4: second response to filled slot 2 must be ignored
      do_rsp(2, 32'hFFFF_0000, 1'b0);

      // R8: partial take on slot 0
      dec_step("R8 first view", 2'b01, 2'b11, VEC[0]);
      dec_step("R8 lane1 held", 2'b10, 2'b10, VEC[0]);
      // slot 1, single lane (R5), slot 0 now free: wrap alloc (R2)
      do_req(nv, 0);
      dec_step("R5 one lane", 2'b01, 2'b01, VEC[1]);
      // R4/R10: slot 2 keeps first data and bus error
      dec_step("R4 R10 slot2", 2'b11, 2'b11, VEC[2]);
      dec_step("R6 slot3 waiting", 2'b11, 2'b00, VEC[3]);
      do_rsp(3, VEC[3].addr, VEC[3].err);
      dec_step("R6 slot3", 2'b11, 2'b11, VEC[3]);
      dec_step("R6 wrapped head waiting", 2'b11, 2'b00, nv);

      // R11: flush with simultaneous request
      @(negedge clk);
      flush_valid = 1; req_valid = 1; req_addr = fv.addr; req_lane_en = fv.en;
      #2 chk("R11 flush_ready", 64'(flush_ready), 64'(1));
      @(posedge clk); #1 begin flush_valid = 0; req_valid = 0; end
      @(negedge clk); #2;
      chk("R11 after flush", 64'({dec_valid, req_ready, req_tag}), 64'({2'b00, 1'b1, 2'b00}));

      // R4: stale response to flushed slot 0 ignored
      do_rsp(0, nv.addr, 1'b0);
      dec_step("R4 stale rsp", 2'b11, 2'b00, nv);

      do_req(gv, 0);
      // R11: the request dropped with the flush left slot 1 empty
      do_rsp(1, fv.addr, 1'b0);
      do_rsp(0, gv.addr, gv.err);
      dec_step("R11 post flush", 2'b11, 2'b11, gv);
      dec_step("R11 dropped req", 2'b11, 2'b00, fv);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule